// File: doc/BRIEF.md
# Cascaded Match Flag Chain

This block joins the match results of several identical search stages into one priority chain. Stage 0 has the highest priority and stage N-1 the lowest. Each stage takes the active-low match flag of the stage above it, its own local match result, a per-stage flag enable from its control register, and an active-low chain enable. It passes an active-low match flag on to the stage below. The flag leaving the last stage is the match result for the whole system. Each stage also reports whether it owns the highest-priority match.

A device access is framed by two one-clock strobes: `cyc_start` opens the access and `cyc_end` closes it. The chain enable is sampled on `cyc_start`. The local result is captured on `cyc_end`, and the flags take their new values on the clock after `cyc_end`. A per-stage `cfg_switch` pulse marks a change of the active configuration set and silences that stage's flag. No data stream passes through the block, so every pin is a plain level or strobe with no valid/ready handshake and no back-pressure. Hold the chain enables high while the system is being initialised.

Top module: `match_chain`

## Requirements
- R1: After reset, every `mf_out_n` bit and `sys_match_n` are 1, and every `owner` bit is 0.
- R2: If `chain_en_n[k]` is 1 on the last `cyc_start` before a `cyc_end`, stage k drives `mf_out_n[k]`=1 after that `cyc_end`, whatever its local result and upstream flag.
- R3: If stage k is enabled and `local_hit[k]` and `flag_en[k]` are both 1 on `cyc_end`, `mf_out_n[k]` is 0 from the next clock.
- R4: An enabled stage drives its flag low whenever its upstream flag is low, even without a local match. The flag ripples down the chain with no clock delay.
- R5: For an enabled stage with `flag_en[k]`=0, `mf_out_n[k]` equals the upstream flag.
- R6: Outside a `cyc_end` or `cfg_switch[k]` strobe, `mf_out_n[k]` holds its value, so changes of `local_hit` and `flag_en` between strobes have no effect.
- R7: A `cfg_switch[k]` pulse sets `mf_out_n[k]` to 1 on the next clock. It takes precedence over a `cyc_end` in the same clock. The stage stays silent until the next `cyc_end`.
- R8: `sys_match_n` equals `mf_out_n[N_STAGES-1]`.
- R9: `owner[k]` is 1 exactly when stage k is enabled, has a captured local match and its upstream flag is 1. At most one `owner` bit is set.
- R10: The upstream flag of stage 0 is tied to 1, so stage 0 owns any match that it captures while enabled.
- R11: Changes of `chain_en_n` between `cyc_start` strobes have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Access start strobe; samples the chain enables |
| cyc_end | input | 1 | Access end strobe; captures local results and publishes the flags |
| chain_en_n | input | N_STAGES | Active-low chain enable per stage |
| flag_en | input | N_STAGES | Match-flag enable bit per stage |
| local_hit | input | N_STAGES | Local valid match per stage |
| cfg_switch | input | N_STAGES | Configuration set change pulse per stage |
| mf_out_n | output | N_STAGES | Active-low match flag leaving each stage; bit k is stage k |
| sys_match_n | output | 1 | Active-low system match (last stage flag) |
| owner | output | N_STAGES | Stage holds the highest-priority match |

## Verification
The bench builds the chain with `N_STAGES`=4. This gives a head stage with a tied input, two middle stages and a tail stage. With that depth the bench can drive a low flag from a high-priority stage across a disabled middle stage, run a pass-through stage between two matching stages, and silence a stage in mid-chain with a configuration switch. A behavioural model compares every flag and owner bit on every clock, across directed cases and a run of random accesses.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  // captured per-stage flag state published at the end of an access
  typedef struct packed {
    logic live;  // chain enabled for the published access
    logic hit;   // local match with flag enable, captured at access end
  } stage_state_t;
endpackage

// File: rtl/mfc_en_latch.sv
module mfc_en_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic cyc_end,
  input  logic cfg_switch,
  input  logic chain_en_n,
  output logic live
);
  logic armed_q;
  logic live_q;

  // enable sampled at the opening strobe only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b0;
    else if (cyc_start) armed_q <= ~chain_en_n;
  end

  // published at the closing strobe; a config change silences it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          live_q <= 1'b0;
    else if (cfg_switch) live_q <= 1'b0;
    else if (cyc_end)    live_q <= armed_q;
  end

  assign live = live_q;
endmodule

// File: rtl/mfc_flag_cell.sv
module mfc_flag_cell
  import mfc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_end,
  input  logic cfg_switch,
  input  logic live,
  input  logic local_hit,
  input  logic flag_en,
  input  logic mf_in_n,
  output logic mf_out_n,
  output logic owner
);
  logic hit_q;
  stage_state_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hit_q <= 1'b0;
    else if (cfg_switch) hit_q <= 1'b0;
    else if (cyc_end)    hit_q <= local_hit & flag_en;
  end

  always_comb begin
    st.live = live;
    st.hit  = hit_q;
    if (st.live) mf_out_n = ~st.hit & mf_in_n;
    else         mf_out_n = 1'b1;
    owner = st.live & st.hit & mf_in_n;
  end
endmodule

// File: rtl/match_chain.sv
module match_chain #(
  parameter int N_STAGES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cyc_start,
  input  logic                cyc_end,
  input  logic [N_STAGES-1:0] chain_en_n,
  input  logic [N_STAGES-1:0] flag_en,
  input  logic [N_STAGES-1:0] local_hit,
  input  logic [N_STAGES-1:0] cfg_switch,
  output logic [N_STAGES-1:0] mf_out_n,
  output logic                sys_match_n,
  output logic [N_STAGES-1:0] owner
);
  localparam int LAST = N_STAGES - 1;

  logic [N_STAGES:0]   link_n;
  logic [N_STAGES-1:0] live;

  assign link_n[0] = 1'b1;  // head stage sees no upstream match

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    mfc_en_latch u_en (
      .clk        (clk),
      .rst_n      (rst_n),
      .cyc_start  (cyc_start),
      .cyc_end    (cyc_end),
      .cfg_switch (cfg_switch[k]),
      .chain_en_n (chain_en_n[k]),
      .live       (live[k])
    );
    mfc_flag_cell u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .cyc_end    (cyc_end),
      .cfg_switch (cfg_switch[k]),
      .live       (live[k]),
      .local_hit  (local_hit[k]),
      .flag_en    (flag_en[k]),
      .mf_in_n    (link_n[k]),
      .mf_out_n   (link_n[k+1]),
      .owner      (owner[k])
    );
  end

  assign mf_out_n    = link_n[N_STAGES:1];
  assign sys_match_n = link_n[LAST+1];
endmodule

// File: rtl/match_chain_chk.sv
module match_chain_chk #(
  parameter int N_STAGES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cyc_end,
  input logic [N_STAGES-1:0] cfg_switch,
  input logic [N_STAGES-1:0] mf_out_n,
  input logic                sys_match_n,
  input logic [N_STAGES-1:0] owner
);
  // R9: a single highest-priority owner
  p_one_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner));

  // R8: system flag reflects the tail stage after every clock
  p_sys_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_out_n[N_STAGES-1] |-> !sys_match_n);

  // R6: the head flag only moves on a strobe
  p_head_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_end && !cfg_switch[0]) |=> $stable(mf_out_n[0]));

  for (genvar k = 0; k < N_STAGES; k++) begin : g_chk
    // R7: configuration change silences the stage on the next clock
    p_cfg_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_switch[k] |=> mf_out_n[k]);
    // R9: an owner always drives its flag low
    p_owner_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      owner[k] |-> !mf_out_n[k]);
    if (k > 0) begin : g_up
      // R9: an owner sees no match above it
      p_owner_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        owner[k] |-> mf_out_n[k-1]);
    end
  end
endmodule

bind match_chain match_chain_chk #(.N_STAGES(N_STAGES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cyc_end     (cyc_end),
  .cfg_switch  (cfg_switch),
  .mf_out_n    (mf_out_n),
  .sys_match_n (sys_match_n),
  .owner       (owner)
);

// File: tb/match_chain_bench.sv
module match_chain_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cyc_start = 1'b0;
  logic         cyc_end = 1'b0;
  logic [N-1:0] chain_en_n = '1;
  logic [N-1:0] flag_en = '0;
  logic [N-1:0] local_hit = '0;
  logic [N-1:0] cfg_switch = '0;
  logic [N-1:0] mf_out_n;
  logic         sys_match_n;
  logic [N-1:0] owner;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  // reference state
  bit m_armed [N];
  bit m_live [N];
  bit m_hit [N];

  always #10 clk = ~clk;  // 50 MHz

  match_chain #(.N_STAGES(N)) u_match_chain (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_end(cyc_end),
    .chain_en_n(chain_en_n), .flag_en(flag_en), .local_hit(local_hit),
    .cfg_switch(cfg_switch), .mf_out_n(mf_out_n), .sys_match_n(sys_match_n),
    .owner(owner)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        m_armed[k] = 0; m_live[k] = 0; m_hit[k] = 0;
      end
    end else begin
      for (int k = 0; k < N; k++) begin
        bit old_armed;
        old_armed = m_armed[k];
        if (cyc_start) m_armed[k] = !chain_en_n[k];
        if (cfg_switch[k]) begin
          m_live[k] = 0; m_hit[k] = 0;
        end else if (cyc_end) begin
          m_live[k] = old_armed;
          m_hit[k]  = local_hit[k] && flag_en[k];
        end
      end
    end
  end

  function automatic logic [2*N:0] model_out();
    logic [N-1:0] f;
    logic [N-1:0] o;
    bit up;
    up = 1;
    for (int k = 0; k < N; k++) begin
      f[k] = m_live[k] ? (!m_hit[k] && up) : 1'b1;
      o[k] = m_live[k] && m_hit[k] && up;
      up = f[k];
    end
    return {f[N-1], o, f};
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2*N:0] e;
      e = model_out();
      checks++;
      if ({sys_match_n, owner, mf_out_n} !== e) begin
        fails++;
        $display("FAIL %s: sys/owner/flags actual %b expected %b", cur_req,
                 {sys_match_n, owner, mf_out_n}, e);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one access: enable sampled at start, results captured at end
  task automatic access(logic [N-1:0] en_n, logic [N-1:0] hit, logic [N-1:0] fe);
    @(negedge clk); chain_en_n = en_n; cyc_start = 1;
    @(negedge clk); cyc_start = 0; local_hit = hit; flag_en = fe;
    @(negedge clk); cyc_end = 1;
    @(negedge clk); cyc_end = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {sys_match_n, owner, mf_out_n}, {1'b1, 4'b0000, 4'b1111});
    rst_n = 1;
    @(negedge clk);
    chk("R1", {owner, mf_out_n}, {4'b0000, 4'b1111});

    cur_req = "R3";
    access(4'b0000, 4'b0100, 4'b1111);
    chk("R3", mf_out_n, 4'b1011 & 4'b0011 | 4'b0000);
    chk("R8", sys_match_n, 1'b0);

    cur_req = "R4";
    access(4'b0000, 4'b1010, 4'b1111);
    chk("R4", mf_out_n, 4'b0001);
    chk("R9", owner, 4'b0010);

    cur_req = "R5";
    access(4'b0000, 4'b0010, 4'b1101);
    chk("R5", mf_out_n, 4'b1111);
    access(4'b0000, 4'b0011, 4'b1101);
    chk("R5", mf_out_n, 4'b0000);
    chk("R10", owner, 4'b0001);

    cur_req = "R2";
    access(4'b0100, 4'b0001, 4'b1111);
    chk("R2", mf_out_n, 4'b1100);
    chk("R8", sys_match_n, 1'b1);

    cur_req = "R11";
    @(negedge clk); chain_en_n = 4'b0000; cyc_start = 1;
    @(negedge clk); cyc_start = 0; chain_en_n = 4'b1111;
    local_hit = 4'b1000; flag_en = 4'b1111;
    @(negedge clk); cyc_end = 1;
    @(negedge clk); cyc_end = 0;
    chk("R11", mf_out_n, 4'b0111);

    cur_req = "R6";
    local_hit = 4'b0001;
    repeat (3) @(negedge clk);
    chk("R6", mf_out_n, 4'b0111);

    cur_req = "R7";
    access(4'b0000, 4'b0001, 4'b1111);
    chk("R7", mf_out_n, 4'b0000);
    cfg_switch = 4'b0001; cyc_end = 1;
    @(negedge clk); cfg_switch = 0; cyc_end = 0;
    chk("R7", mf_out_n, 4'b1111);
    chk("R9", owner, 4'b0000);

    cur_req = "random";
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      chain_en_n = N'($urandom); cyc_start = ($urandom % 3) == 0;
      local_hit = N'($urandom); flag_en = N'($urandom);
      cyc_end = ($urandom % 3) == 0;
      cfg_switch = (($urandom % 5) == 0) ? N'($urandom) : '0;
    end
    @(negedge clk); cyc_start = 0; cyc_end = 0; cfg_switch = 0;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule